// File: doc/BRIEF.md
# Write Protection and Status Controller

This block sits beside the serial command engine of a small serial-bus nonvolatile memory. It holds the status register and decides whether a requested array write or status write may go ahead. The engine gives it one strobe per decoded command: latch enable, latch disable, status write with its two protect bits, and array write with the page start address. It also sends a strobe for every serial bit that arrives after such a command. The controller arms that command and acts on it only when chip select returns high straight after the command's last bit.

A write that is allowed starts a self-timed write cycle. Its length is a clock-cycle count set by a parameter, standing in for the millisecond-scale programming time. While the cycle runs, the block reports busy, the status byte reads all ones, and every new command is dropped. An array write gets a one-cycle grant pulse at the start of its cycle. A status write moves the new protect code into place when its cycle ends. The protect code marks none, the top quarter, the top half, or all of the address space as read-only.

Top module: `wp_status_ctrl`

## Requirements
- R1: Outside a write cycle the status byte reads bit 0 = 0, bit 1 = write-enable latch, bits 3:2 = protect code and bits 7:4 = 0. After reset it reads 0x00.
- R2: An enable strobe sets the latch, and a disable strobe clears it. Each takes effect on the rising edge of chip select (cs_ni), and only if no ser_bit_i strobe came between the command and that edge.
- R3: The latch clears in the cycle after every completed array or status write cycle ends.
- R4: The protect code selects the read-only region by the page start address. Code 0 protects nothing, code 1 protects addresses with both top bits set, code 2 protects addresses with the top bit set, and code 3 protects every address.
- R5: An array or status write starts only if the latch is set and wp_ni stays high from the command strobe until chip select rises. If it does not, there is no grant, no busy and the latch keeps its value.
- R6: A write cycle keeps busy_o high for exactly WC_CYCLES cycles. For that whole time the status byte reads 0xFF.
- R7: A status write loads its two data bits into the protect code when its cycle ends.
- R8: Commands that arrive during a write cycle are dropped. wp_ni going low during the cycle does not shorten it or cancel it.
- R9: An array write to a protected page produces no grant and no busy, but still clears the latch.
- R10: grant_o is a single-cycle pulse in the first busy cycle of an unprotected array write. It never fires for a status write.
- R11: A rise of chip select with no command armed changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| wp_ni | input | 1 | Hardware write protect, low blocks writes |
| ser_bit_i | input | 1 | Strobe for each serial bit after a decoded command |
| wen_req_i | input | 1 | Enable-latch command decoded |
| wdi_req_i | input | 1 | Disable-latch command decoded |
| sr_req_i | input | 1 | Status-write data byte received |
| sr_bp_i | input | BPW | New protect code carried with sr_req_i |
| arr_req_i | input | 1 | Array-write data byte received |
| arr_addr_i | input | AW | Page start address carried with arr_req_i |
| status_o | output | SW | Status byte |
| busy_o | output | 1 | Write cycle running |
| grant_o | output | 1 | One-cycle grant to the array |

## Verification
The bench targets the corner cases where a wrong design fails quietly.

- A serial bit arriving after a command, before chip select rises, must cancel it. A design that commits anyway would set the latch or start writes that the host abandoned.
- A short low pulse on wp_ni before chip select rises must cancel the write. A design that checks write protect only at the edge would let that write through.
- A low pulse on wp_ni during a running cycle must have no effect. A design that reacts to it would abort the cycle.
- An enable command issued during busy must be dropped. A design that accepts it would leave the latch set after the cycle.
- An array write to a protected page must clear the latch. A design that skips this would leave the latch armed for the next attempt.
- The busy window is counted cycle by cycle. An off-by-one in the counter shows up as a mismatch against WC_CYCLES.

// File: rtl/wpsc_pkg.sv
package wpsc_pkg;
  typedef enum logic [2:0] {
    ARM_NONE = 3'd0,
    ARM_WEN  = 3'd1,
    ARM_WDI  = 3'd2,
    ARM_SR   = 3'd3,
    ARM_ARR  = 3'd4
  } arm_e;
endpackage

// File: rtl/wpsc_cmd_arm.sv
module wpsc_cmd_arm
  import wpsc_pkg::*;
#(
  parameter int AW  = 8,
  parameter int BPW = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cs_ni,
  input  logic           wp_ni,
  input  logic           ser_bit_i,
  input  logic           busy_i,
  input  logic           wen_req_i,
  input  logic           wdi_req_i,
  input  logic           sr_req_i,
  input  logic [BPW-1:0] sr_bp_i,
  input  logic           arr_req_i,
  input  logic [AW-1:0]  arr_addr_i,
  output logic           commit_o,
  output arm_e           kind_o,
  output logic [BPW-1:0] bp_o,
  output logic [AW-1:0]  addr_o
);
  arm_e           arm_q, arm_d;
  logic           cs_q;
  logic [BPW-1:0] bp_q;
  logic [AW-1:0]  addr_q;

  always_comb begin
    arm_d = arm_q;
    if (busy_i || cs_ni)                          arm_d = ARM_NONE;
    else if (wen_req_i)                           arm_d = ARM_WEN;
    else if (wdi_req_i)                           arm_d = ARM_WDI;
    else if (sr_req_i)                            arm_d = ARM_SR;
    else if (arr_req_i)                           arm_d = ARM_ARR;
    else if (ser_bit_i)                           arm_d = ARM_NONE;
    else if (!wp_ni && (arm_q == ARM_SR || arm_q == ARM_ARR)) arm_d = ARM_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= ARM_NONE;
      cs_q   <= 1'b1;
      bp_q   <= '0;
      addr_q <= '0;
    end else begin
      arm_q <= arm_d;
      cs_q  <= cs_ni;
      if (sr_req_i && !cs_ni)  bp_q   <= sr_bp_i;
      if (arr_req_i && !cs_ni) addr_q <= arr_addr_i;
    end
  end

  // commit on chip-select rise, using the arm state held up to that edge
  assign commit_o = cs_ni && !cs_q && (arm_q != ARM_NONE) && !busy_i;
  assign kind_o   = arm_q;
  assign bp_o     = bp_q;
  assign addr_o   = addr_q;
endmodule

// File: rtl/wpsc_bp_decode.sv
module wpsc_bp_decode #(
  parameter int AW  = 8,
  parameter int BPW = 2
) (
  input  logic [BPW-1:0] bp_i,
  input  logic [AW-1:0]  addr_i,
  output logic           prot_o
);
  always_comb begin
    unique case (bp_i)
      2'd0:    prot_o = 1'b0;
      2'd1:    prot_o = &addr_i[AW-1:AW-2];
      2'd2:    prot_o = addr_i[AW-1];
      default: prot_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wpsc_wc_timer.sv
module wpsc_wc_timer #(
  parameter int WC_CYCLES = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(WC_CYCLES + 1);
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      cnt_q  <= CW'(WC_CYCLES - 1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/wp_status_ctrl.sv
module wp_status_ctrl
  import wpsc_pkg::*;
#(
  parameter int AW        = 8,
  parameter int BPW       = 2,
  parameter int SW        = 8,
  parameter int WC_CYCLES = 40
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cs_ni,
  input  logic           wp_ni,
  input  logic           ser_bit_i,
  input  logic           wen_req_i,
  input  logic           wdi_req_i,
  input  logic           sr_req_i,
  input  logic [BPW-1:0] sr_bp_i,
  input  logic           arr_req_i,
  input  logic [AW-1:0]  arr_addr_i,
  output logic [SW-1:0]  status_o,
  output logic           busy_o,
  output logic           grant_o
);
  localparam int PADW = SW - BPW - 2;

  logic           commit, prot, busy, done;
  arm_e           kind;
  logic [BPW-1:0] arm_bp;
  logic [AW-1:0]  arm_addr;
  logic           wel_q, sr_pend_q, grant_q;
  logic [BPW-1:0] bp_q, bp_new_q;
  logic           allowed, start_sr, arr_ok, start_arr, prot_drop;

  wpsc_cmd_arm #(.AW(AW), .BPW(BPW)) u_arm (
    .clk_i, .rst_ni, .cs_ni, .wp_ni, .ser_bit_i,
    .busy_i(busy), .wen_req_i, .wdi_req_i, .sr_req_i, .sr_bp_i,
    .arr_req_i, .arr_addr_i,
    .commit_o(commit), .kind_o(kind), .bp_o(arm_bp), .addr_o(arm_addr)
  );

  wpsc_bp_decode #(.AW(AW), .BPW(BPW)) u_dec (
    .bp_i(bp_q), .addr_i(arm_addr), .prot_o(prot)
  );

  wpsc_wc_timer #(.WC_CYCLES(WC_CYCLES)) u_tmr (
    .clk_i, .rst_ni, .start_i(start_sr || start_arr), .busy_o(busy), .done_o(done)
  );

  assign allowed   = wel_q && wp_ni;
  assign start_sr  = commit && (kind == ARM_SR) && allowed;
  assign arr_ok    = commit && (kind == ARM_ARR) && allowed;
  assign start_arr = arr_ok && !prot;
  assign prot_drop = arr_ok && prot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q     <= 1'b0;
      bp_q      <= '0;
      bp_new_q  <= '0;
      sr_pend_q <= 1'b0;
      grant_q   <= 1'b0;
    end else begin
      grant_q <= start_arr;
      if (done)                              wel_q <= 1'b0;
      else if (commit && kind == ARM_WEN)    wel_q <= 1'b1;
      else if (commit && kind == ARM_WDI)    wel_q <= 1'b0;
      else if (prot_drop)                    wel_q <= 1'b0;
      if (start_sr) begin
        sr_pend_q <= 1'b1;
        bp_new_q  <= arm_bp;
      end else if (done) begin
        sr_pend_q <= 1'b0;
        if (sr_pend_q) bp_q <= bp_new_q;
      end
    end
  end

  assign status_o = busy ? {SW{1'b1}} : {{PADW{1'b0}}, bp_q, wel_q, 1'b0};
  assign busy_o   = busy;
  assign grant_o  = grant_q;
endmodule

// File: rtl/wpsc_chk.sv
module wpsc_chk #(
  parameter int SW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_ni,
  input logic          wp_ni,
  input logic [SW-1:0] status_o,
  input logic          busy_o,
  input logic          grant_o
);
  // R1
  idle_layout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (status_o[SW-1:4] == '0) && !status_o[0]);
  // R6
  busy_all_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (status_o == {SW{1'b1}}));
  // R3
  wel_clear_after_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !status_o[1]);
  // R5
  grant_needs_wel_wp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> $past(status_o[1]) && $past(wp_ni));
  // R10
  grant_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> busy_o ##1 !grant_o);
  // R2
  wel_set_at_cs_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(status_o[1]) && !busy_o) |-> $past(cs_ni));
endmodule

bind wp_status_ctrl wpsc_chk #(.SW(SW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .wp_ni(wp_ni),
  .status_o(status_o), .busy_o(busy_o), .grant_o(grant_o)
);

// File: tb/sim_wp_status_ctrl.sv
module sim_wp_status_ctrl;
  localparam int AW = 8, BPW = 2, SW = 8, WC = 40;
  localparam int OP_WEN = 0, OP_WDI = 1, OP_SR = 2, OP_ARR = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, wp_ni = 1'b1, ser_bit_i = 1'b0;
  logic wen_req_i = 1'b0, wdi_req_i = 1'b0, sr_req_i = 1'b0, arr_req_i = 1'b0;
  logic [BPW-1:0] sr_bp_i = '0;
  logic [AW-1:0]  arr_addr_i = '0;
  logic [SW-1:0]  status_o;
  logic busy_o, grant_o;

  int checks = 0, errors = 0;
  logic m_wel = 1'b0;
  logic [1:0] m_bp = 2'd0;
  logic s_grant, s_busy;
  logic [SW-1:0] s_stat;

  always #4 clk = ~clk;

  wp_status_ctrl #(.AW(AW), .BPW(BPW), .SW(SW), .WC_CYCLES(WC)) u0 (
    .clk_i(clk), .rst_ni, .cs_ni, .wp_ni, .ser_bit_i, .wen_req_i, .wdi_req_i,
    .sr_req_i, .sr_bp_i, .arr_req_i, .arr_addr_i, .status_o, .busy_o, .grant_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit is_prot(input logic [1:0] bp, input logic [AW-1:0] a);
    case (bp)
      2'd0: return 1'b0;
      2'd1: return a[7] && a[6];
      2'd2: return a[7];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] idle_stat();
    return {4'b0, m_bp, m_wel, 1'b0};
  endfunction

  task automatic issue(input int op, input logic [1:0] bp, input logic [AW-1:0] a,
                       input bit extra, input bit wpdrop);
    @(negedge clk) cs_ni = 1'b0;
    @(negedge clk);
    wen_req_i = (op == OP_WEN); wdi_req_i = (op == OP_WDI);
    sr_req_i = (op == OP_SR); arr_req_i = (op == OP_ARR);
    sr_bp_i = bp; arr_addr_i = a;
    @(negedge clk);
    {wen_req_i, wdi_req_i, sr_req_i, arr_req_i} = '0;
    ser_bit_i = extra;
    @(negedge clk);
    ser_bit_i = 1'b0;
    if (wpdrop) wp_ni = 1'b0;
    @(negedge clk);
    wp_ni = 1'b1; cs_ni = 1'b1;
    @(negedge clk);
    s_grant = grant_o; s_busy = busy_o; s_stat = status_o;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic txn(input int op, input logic [1:0] bp, input logic [AW-1:0] a,
                     input bit extra, input bit wpdrop);
    bit acc, exp_busy, exp_grant;
    int n;
    issue(op, bp, a, extra, wpdrop);
    acc = !extra;
    exp_busy = 1'b0; exp_grant = 1'b0;
    if (op == OP_WEN && acc) m_wel = 1'b1;
    if (op == OP_WDI && acc) m_wel = 1'b0;
    if ((op == OP_SR || op == OP_ARR) && acc && m_wel && !wpdrop) begin
      if (op == OP_ARR && is_prot(m_bp, a)) m_wel = 1'b0;   // R9
      else begin
        exp_busy = 1'b1;
        exp_grant = (op == OP_ARR);
      end
    end
    chk(s_grant == exp_grant, "R10 grant", s_grant, exp_grant);
    chk(s_busy == exp_busy, "R5 busy start", s_busy, exp_busy);
    if (exp_busy) begin
      chk(s_stat == 8'hFF, "R6 busy status", s_stat, 8'hFF);
      count_busy(n);
      chk(n == WC, "R6 busy length", n, WC);
      m_wel = 1'b0;
      if (op == OP_SR) m_bp = bp;
    end
    chk(status_o == idle_stat(), "R1 idle status", status_o, idle_stat());
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, op;
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    chk(status_o == 8'h00, "R1 reset status", status_o, 0);
    chk(!busy_o && !grant_o, "R1 reset busy", {busy_o, grant_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R11: bare chip-select pulse
    @(negedge clk) cs_ni = 1'b0;
    @(negedge clk) cs_ni = 1'b1;
    @(negedge clk);
    chk(status_o == 8'h00 && !busy_o, "R11 bare cs", status_o, 0);
    // R5: write without latch
    txn(OP_ARR, 0, 8'h10, 0, 0);
    // R2: enable cancelled by extra bit, then accepted
    txn(OP_WEN, 0, 0, 1, 0);
    chk(status_o[1] == 1'b0, "R2 cancelled enable", status_o[1], 0);
    txn(OP_WEN, 0, 0, 0, 0);
    chk(status_o[1] == 1'b1, "R2 enable", status_o[1], 1);
    txn(OP_WDI, 0, 0, 0, 0);
    chk(status_o[1] == 1'b0, "R2 disable", status_o[1], 0);
    // R7: status write sets code 1
    txn(OP_WEN, 0, 0, 0, 0);
    txn(OP_SR, 2'd1, 0, 0, 0);
    chk(status_o == 8'h04, "R7 protect code", status_o, 8'h04);
    // R9 / R4: protected top-quarter write
    txn(OP_WEN, 0, 0, 0, 0);
    txn(OP_ARR, 0, 8'hC4, 0, 0);
    chk(status_o[1] == 1'b0, "R9 latch cleared", status_o[1], 0);
    // R4: unprotected write below region, R3 latch clears
    txn(OP_WEN, 0, 0, 0, 0);
    txn(OP_ARR, 0, 8'hBC, 0, 0);
    chk(status_o[1] == 1'b0, "R3 latch after cycle", status_o[1], 0);
    // R5: WP low pulse before chip select rise cancels
    txn(OP_WEN, 0, 0, 0, 0);
    txn(OP_ARR, 0, 8'h00, 0, 1);
    chk(status_o[1] == 1'b1, "R5 latch kept", status_o[1], 1);
    // R8: commands and WP during busy
    issue(OP_ARR, 0, 8'h20, 0, 0);
    chk(s_grant && s_busy, "R8 start", {s_grant, s_busy}, 3);
    @(negedge clk) cs_ni = 1'b0;
    @(negedge clk) wen_req_i = 1'b1; wp_ni = 1'b0;
    @(negedge clk) wen_req_i = 1'b0;
    @(negedge clk) cs_ni = 1'b1; wp_ni = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b1, "R8 wp no abort", busy_o, 1);
    count_busy(n);
    chk(n == WC - 5, "R8 busy length", n, WC - 5);
    chk(status_o == 8'h04, "R8 enable dropped", status_o, 8'h04);
    m_wel = 1'b0; m_bp = 2'd1;
    // random mix
    for (int i = 0; i < 250; i++) begin
      op = $urandom_range(0, 5);
      if (op > 3) op = OP_WEN;
      txn(op, 2'($urandom), 8'($urandom), ($urandom_range(0, 7) == 0),
          ($urandom_range(0, 7) == 0));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule